// File: doc/BRIEF.md
# Platform System Control Port Bank

A byte-wide register bank on a simple I/O port bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. The bank decodes a fixed set of port addresses. Most of them return board identity and status constants. A few hold state that software reads back through a mask: a cache-control nibble, a map-type bit and two scratch bytes. The rest turn writes into level or pulse outputs.

The outputs are:
- a soft-reset level and a little-endian mode flag, both written through one control port;
- a lamp output;
- two single-cycle pulses that toggle the password locks of an external NVRAM;
- the map-mode bit, which an address translator downstream uses to choose between a contiguous and a scattered I/O layout.

A read of any port the bank does not decode returns all ones. A write to such a port changes nothing.

Top module: `sysport_bank`

## Requirements
- R1: After reset, soft_rst, le_mode, lamp, lock_a_pls, lock_b_pls, map_mode and rdata are all 0, and every stored register is 0.
- R2: A write to port 0x092 sets soft_rst to data bit 0 and le_mode to data bit 1. A read of 0x092 returns 0x00.
- R3: Reads return fixed constants: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03. A write to 0x800, 0x802 or 0x803 changes no output and no read value.
- R4: A write to port 0x808 sets lamp to data bit 0.
- R5: A write to 0x810 raises lock_a_pls for exactly the one cycle after the write edge. A write to 0x812 does the same for lock_b_pls. Neither pulse rises at any other time.
- R6: A write to 0x81C stores data bits 3:0. A read of 0x81C returns them with bits 7:4 zero.
- R7: A write to 0x850 stores data bit 0 as map_mode. A read of 0x850 returns {7'b0, map_mode}.
- R8: Ports 0x398 and 0x399 are independent 8-bit read/write scratch bytes.
- R9: A read of any other address returns 0xFF; this includes 0x801, 0x808, 0x812 and 0x814. A write to an address that is not decoded changes no output and no stored value.
- R10: rdata takes the value of the addressed port at the clock edge where rd_en is high, using the state from before any write at that same edge. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| lamp | output | 1 | Disk activity lamp |
| lock_a_pls | output | 1 | Lock 1 toggle pulse |
| lock_b_pls | output | 1 | Lock 2 toggle pulse |
| map_mode | output | 1 | I/O map type select |

## Verification
The assertions assume that the strobes hold low while reset is asserted. Several properties look one cycle back at the strobes, so a strobe during reset would make them misfire. The assertions also assume that only one strobe is high in any cycle, so that every change of an output can be traced to a single write or read. The stimulus meets both assumptions. It drives inputs on the falling edge, keeps both strobes low through reset, and issues each access as a single write or a single read, never as both at once. The accesses, directed and random, are drawn from the decoded ports together with gap addresses.

// File: rtl/sysport_bank.sv
module sysport_bank #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              soft_rst,
  output logic              le_mode,
  output logic              lamp,
  output logic              lock_a_pls,
  output logic              lock_b_pls,
  output logic              map_mode
);
  localparam logic [ADDR_W-1:0] P_CTRL  = ADDR_W'(16'h0092);
  localparam logic [ADDR_W-1:0] P_SCR0  = ADDR_W'(16'h0398);
  localparam logic [ADDR_W-1:0] P_SCR1  = ADDR_W'(16'h0399);
  localparam logic [ADDR_W-1:0] P_CPUID = ADDR_W'(16'h0800);
  localparam logic [ADDR_W-1:0] P_FEAT  = ADDR_W'(16'h0802);
  localparam logic [ADDR_W-1:0] P_STAT  = ADDR_W'(16'h0803);
  localparam logic [ADDR_W-1:0] P_LAMP  = ADDR_W'(16'h0808);
  localparam logic [ADDR_W-1:0] P_EQUIP = ADDR_W'(16'h080C);
  localparam logic [ADDR_W-1:0] P_LOCKA = ADDR_W'(16'h0810);
  localparam logic [ADDR_W-1:0] P_LOCKB = ADDR_W'(16'h0812);
  localparam logic [ADDR_W-1:0] P_KEY   = ADDR_W'(16'h0818);
  localparam logic [ADDR_W-1:0] P_CACHE = ADDR_W'(16'h081C);
  localparam logic [ADDR_W-1:0] P_L2ST  = ADDR_W'(16'h0823);
  localparam logic [ADDR_W-1:0] P_MAP   = ADDR_W'(16'h0850);

  logic [3:0] cache_q;
  logic [7:0] scr0_q, scr1_q;
  logic [7:0] rd_mux;

  wire wr_hit_ctrl  = wr_en && addr == P_CTRL;
  wire wr_hit_lamp  = wr_en && addr == P_LAMP;
  wire wr_hit_cache = wr_en && addr == P_CACHE;
  wire wr_hit_map   = wr_en && addr == P_MAP;

  always_comb begin
    unique case (addr)
      P_CTRL:  rd_mux = 8'h00;
      P_SCR0:  rd_mux = scr0_q;
      P_SCR1:  rd_mux = scr1_q;
      P_CPUID: rd_mux = 8'hEF;
      P_FEAT:  rd_mux = 8'hAD;
      P_STAT:  rd_mux = 8'hE0;
      P_EQUIP: rd_mux = 8'h3C;
      P_LOCKA: rd_mux = 8'h39;
      P_KEY:   rd_mux = 8'h00;
      P_CACHE: rd_mux = {4'h0, cache_q};
      P_L2ST:  rd_mux = 8'h03;
      P_MAP:   rd_mux = {7'h00, map_mode};
      default: rd_mux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata      <= '0;
      soft_rst   <= 1'b0;
      le_mode    <= 1'b0;
      lamp       <= 1'b0;
      lock_a_pls <= 1'b0;
      lock_b_pls <= 1'b0;
      map_mode   <= 1'b0;
      cache_q    <= '0;
      scr0_q     <= '0;
      scr1_q     <= '0;
    end else begin
      lock_a_pls <= wr_en && addr == P_LOCKA;
      lock_b_pls <= wr_en && addr == P_LOCKB;
      if (rd_en)        rdata <= rd_mux;
      if (wr_hit_ctrl)  {le_mode, soft_rst} <= wdata[1:0];
      if (wr_hit_lamp)  lamp <= wdata[0];
      if (wr_hit_cache) cache_q <= wdata[3:0];
      if (wr_hit_map)   map_mode <= wdata[0];
      if (wr_en && addr == P_SCR0) scr0_q <= wdata;
      if (wr_en && addr == P_SCR1) scr1_q <= wdata;
    end
  end
endmodule

// File: rtl/sysport_bank_chk.sv
module sysport_bank_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              soft_rst,
  input logic              le_mode,
  input logic              lamp,
  input logic              lock_a_pls,
  input logic              lock_b_pls,
  input logic              map_mode
);
  assert_lock_a_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_a_pls |-> $past(wr_en && addr == ADDR_W'(16'h0810)));
  assert_lock_b_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_b_pls |-> $past(wr_en && addr == ADDR_W'(16'h0812)));
  assert_ctrl_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(soft_rst) || !$stable(le_mode)) |-> $past(wr_en && addr == ADDR_W'(16'h0092)));
  assert_lamp_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lamp) |-> $past(wr_en && addr == ADDR_W'(16'h0808)));
  assert_map_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(map_mode) |-> $past(wr_en && addr == ADDR_W'(16'h0850)));
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(rd_en));
  assert_cpuid_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == ADDR_W'(16'h0800)) |-> rdata == 8'hEF);
  assert_cache_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == ADDR_W'(16'h081C)) |-> rdata[7:4] == 4'h0);
endmodule

bind sysport_bank sysport_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .soft_rst(soft_rst), .le_mode(le_mode), .lamp(lamp),
  .lock_a_pls(lock_a_pls), .lock_b_pls(lock_b_pls), .map_mode(map_mode));

// File: tb/sysport_bank_tb.sv
module sysport_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic soft_rst, le_mode, lamp, lock_a_pls, lock_b_pls, map_mode;

  int vectors = 0, fails = 0;
  bit done = 0;

  sysport_bank #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .soft_rst(soft_rst), .le_mode(le_mode),
    .lamp(lamp), .lock_a_pls(lock_a_pls), .lock_b_pls(lock_b_pls),
    .map_mode(map_mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model
  int idmap[int];
  int m_rdata = 0, m_srst = 0, m_le = 0, m_lamp = 0, m_la = 0, m_lb = 0;
  int m_map = 0, m_cache = 0;
  int m_scr[2] = '{0, 0};

  function automatic int ref_read(int a);
    if (a == 'h398) return m_scr[0];
    if (a == 'h399) return m_scr[1];
    if (a == 'h81C) return m_cache;
    if (a == 'h850) return m_map;
    if (idmap.exists(a)) return idmap[a];
    return 'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdata = 0; m_srst = 0; m_le = 0; m_lamp = 0; m_la = 0; m_lb = 0;
      m_map = 0; m_cache = 0; m_scr[0] = 0; m_scr[1] = 0;
    end else begin
      int a, d;
      a = int'(addr); d = int'(wdata);
      if (rd_en) m_rdata = ref_read(a);
      m_la = (wr_en && a == 'h810) ? 1 : 0;
      m_lb = (wr_en && a == 'h812) ? 1 : 0;
      if (wr_en) begin
        if (a == 'h092) begin m_srst = d % 2; m_le = (d / 2) % 2; end
        if (a == 'h808) m_lamp = d % 2;
        if (a == 'h81C) m_cache = d % 16;
        if (a == 'h850) m_map = d % 2;
        if (a == 'h398) m_scr[0] = d;
        if (a == 'h399) m_scr[1] = d;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) if (!done) begin
    chk("R2", "soft_rst", int'(soft_rst), m_srst);
    chk("R2", "le_mode", int'(le_mode), m_le);
    chk("R4", "lamp", int'(lamp), m_lamp);
    chk("R5", "lock_a_pls", int'(lock_a_pls), m_la);
    chk("R5", "lock_b_pls", int'(lock_b_pls), m_lb);
    chk("R7", "map_mode", int'(map_mode), m_map);
    chk("R10", "rdata", int'(rdata), m_rdata);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    addr = ADDR_W'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_exp(string req, int a, int exp);
    rd(a);
    chk(req, $sformatf("read %0h", a), int'(rdata), exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int pool[$];
    idmap['h092] = 'h00; idmap['h800] = 'hEF; idmap['h802] = 'hAD;
    idmap['h803] = 'hE0; idmap['h80C] = 'h3C; idmap['h810] = 'h39;
    idmap['h818] = 'h00; idmap['h823] = 'h03;
    pool = '{'h092, 'h398, 'h399, 'h800, 'h801, 'h802, 'h803, 'h808, 'h80C,
             'h810, 'h812, 'h814, 'h818, 'h81C, 'h823, 'h850, 'h851, 'h000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset outputs",
        {soft_rst, le_mode, lamp, lock_a_pls, lock_b_pls, map_mode}, 0);
    chk("R1", "reset rdata", int'(rdata), 0);
    rd_exp("R1", 'h81C, 0);
    rd_exp("R1", 'h398, 0);
    // R2
    wr('h092, 'h01);
    chk("R2", "soft_rst set", int'(soft_rst), 1);
    chk("R2", "le_mode clear", int'(le_mode), 0);
    wr('h092, 'h02);
    chk("R2", "soft_rst clear", int'(soft_rst), 0);
    chk("R2", "le_mode set", int'(le_mode), 1);
    rd_exp("R2", 'h092, 'h00);
    // R3 constants and ignored writes
    rd_exp("R3", 'h800, 'hEF); rd_exp("R3", 'h802, 'hAD);
    rd_exp("R3", 'h803, 'hE0); rd_exp("R3", 'h80C, 'h3C);
    rd_exp("R3", 'h810, 'h39); rd_exp("R3", 'h818, 'h00);
    rd_exp("R3", 'h823, 'h03);
    wr('h800, 'h00); wr('h802, 'h11); wr('h803, 'hFF);
    rd_exp("R3", 'h800, 'hEF); rd_exp("R3", 'h802, 'hAD);
    rd_exp("R3", 'h803, 'hE0);
    // R4
    wr('h808, 'hFF); chk("R4", "lamp on", int'(lamp), 1);
    wr('h808, 'hFE); chk("R4", "lamp off", int'(lamp), 0);
    // R5 pulse width
    wr('h810, 'h00);
    chk("R5", "lock_a high after write", int'(lock_a_pls), 1);
    @(negedge clk);
    chk("R5", "lock_a one cycle", int'(lock_a_pls), 0);
    wr('h812, 'h55);
    chk("R5", "lock_b high after write", int'(lock_b_pls), 1);
    chk("R5", "lock_a stays low", int'(lock_a_pls), 0);
    @(negedge clk);
    chk("R5", "lock_b one cycle", int'(lock_b_pls), 0);
    // R6 masking
    wr('h81C, 'hA7); rd_exp("R6", 'h81C, 'h07);
    wr('h81C, 'hFF); rd_exp("R6", 'h81C, 'h0F);
    // R7
    wr('h850, 'hFE); chk("R7", "map clear", int'(map_mode), 0);
    rd_exp("R7", 'h850, 'h00);
    wr('h850, 'h03); chk("R7", "map set", int'(map_mode), 1);
    rd_exp("R7", 'h850, 'h01);
    // R8
    wr('h398, 'h5A); wr('h399, 'hC3);
    rd_exp("R8", 'h398, 'h5A); rd_exp("R8", 'h399, 'hC3);
    // R9 gaps and ignored writes
    rd_exp("R9", 'h801, 'hFF); rd_exp("R9", 'h808, 'hFF);
    rd_exp("R9", 'h812, 'hFF); rd_exp("R9", 'h814, 'hFF);
    wr('h81D, 'h00); wr('h851, 'h00); wr('h093, 'h00);
    rd_exp("R9", 'h81C, 'h0F); rd_exp("R9", 'h850, 'h01);
    chk("R9", "le_mode after gap write", int'(le_mode), 1);
    // R10 hold when idle
    rd('h800);
    repeat (3) @(negedge clk);
    chk("R10", "rdata held", int'(rdata), 'hEF);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      a = pool[$urandom_range(pool.size() - 1)];
      if ($urandom_range(1) == 1) wr(a, int'($urandom_range(255)));
      else rd(a);
      if ($urandom_range(3) == 0) @(negedge clk);
    end
    @(negedge clk);
    finish_run();
  end
endmodule